// File: doc/BRIEF.md
# Sequential Integer Divider with Operand and Result Shifters

This block divides two integers one bit per cycle and handles both signed and unsigned operands. Software-style register writes load a dividend, a divisor and a configuration word through a single write port. Before the iteration starts, the dividend is shifted left by a programmable count and the divisor is shifted right by a programmable count. The right shift lets a left-aligned narrow value, such as a 24-bit result held in the top bits of a word, be brought down to its integer part. After the iteration, the quotient can be shifted left or right by a third programmable count. The remainder is never shifted.

A division is launched by the `start_i` strobe. When auto-start is selected, writing the divisor register also launches it, so the dividend must be written first. The operands and the configuration are captured at launch. `busy_o` covers the whole operation. A one-cycle `done_o` pulse marks the cycle in which the quotient, the remainder and the divide-by-zero flag take their new values.

Top module: `shift_divider`

## Requirements
- R1: Writing with `wr_sel_i` = 0 loads the dividend, 1 loads the divisor and 2 loads the configuration word; code 3 is ignored. With bit 0 of the configuration clear, the operands are unsigned and the results satisfy quot = a / b and rem = a mod b, where a and b are the shifted operands.
- R2: With configuration bit 0 set, the operands are two's complement. The quotient truncates toward zero and the remainder takes the sign of the shifted dividend. The most negative value divided by -1 wraps to the most negative value.
- R3: Before dividing, the dividend is shifted left by the count in configuration bits [6:2]. Bits shifted out are lost.
- R4: Before dividing, the divisor is shifted right by the count in configuration bits [11:7]. The shift is logical in unsigned mode and arithmetic in signed mode.
- R5: The quotient is shifted by the count in configuration bits [16:12]. Bit 17 set selects a right shift, which is arithmetic in signed mode and logical in unsigned mode; bit 17 clear selects a left shift. The remainder is not shifted.
- R6: The results appear exactly 35 clock cycles after the launching edge. `busy_o` is high from the cycle after that edge until the results appear.
- R7: `done_o` is high for exactly one cycle, in the same cycle that the new results appear, and `busy_o` is low in that cycle.
- R8: With configuration bit 1 clear (auto-start), any divisor write accepted while idle launches a division using the written value. With bit 1 set, a divisor write does not launch anything. `start_i` launches a division in both settings.
- R9: A shifted divisor of zero sets `div_zero_o` and leaves the remainder equal to the shifted dividend. The quotient becomes all ones in unsigned mode. In signed mode it becomes 0x7FFFFFFF for a non-negative dividend and 0x80000000 for a negative one. The post-shift is skipped in this case. The flag is recomputed at every completion.
- R10: While busy, `start_i` and divisor writes do not launch or disturb the running division. Register writes made while busy still update the registers and are used by the next division.
- R11: After reset the block is idle, `done_o` is low, and the quotient, remainder and error flag read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select: 0 dividend, 1 divisor, 2 configuration |
| wr_data_i | input | 32 | Write data |
| start_i | input | 1 | Launch strobe |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last division had a zero divisor |
| quot_o | output | 32 | Quotient after post-shift |
| rem_o | output | 32 | Remainder |

## Verification
The assertions assume that every input is a known value from reset onward and that the operand registers change only through the write port. Under those conditions the latency counter, the invariant that the remainder stays below the divisor, and the check that the captured operands stay stable while busy all hold.

The stimulus drives every input on the falling clock edge and writes at most one register per cycle. All shift counts come from five-bit fields, so no count can exceed the word width. Random operands are mixed with directed sign, overflow, zero-divisor and busy-collision cases.

// File: rtl/shdiv_pkg.sv
package shdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_ITER,
    ST_FIX,
    ST_POST
  } state_e;

  localparam logic [1:0] SEL_DVD = 2'd0;
  localparam logic [1:0] SEL_DVS = 2'd1;
  localparam logic [1:0] SEL_CFG = 2'd2;
endpackage

// File: rtl/shdiv_prep.sv
module shdiv_prep #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dvd_i,
  input  logic [WIDTH-1:0] dvs_i,
  input  logic             is_signed_i,
  input  logic [SHW-1:0]   dvd_lsh_i,
  input  logic [SHW-1:0]   dvs_rsh_i,
  output logic [WIDTH-1:0] abs_dvd_o,
  output logic [WIDTH-1:0] abs_dvs_o,
  output logic             neg_quo_o,
  output logic             neg_rem_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] dvd_eff, dvs_eff;
  logic neg_a, neg_b;

  always_comb begin
    dvd_eff = dvd_i << dvd_lsh_i;
    if (is_signed_i) dvs_eff = WIDTH'($signed(dvs_i) >>> dvs_rsh_i);
    else             dvs_eff = dvs_i >> dvs_rsh_i;
    neg_a     = is_signed_i & dvd_eff[WIDTH-1];
    neg_b     = is_signed_i & dvs_eff[WIDTH-1];
    abs_dvd_o = neg_a ? (~dvd_eff + 1'b1) : dvd_eff;
    abs_dvs_o = neg_b ? (~dvs_eff + 1'b1) : dvs_eff;
    neg_quo_o = neg_a ^ neg_b;
    neg_rem_o = neg_a;
    zero_o    = (dvs_eff == '0);
  end
endmodule

// File: rtl/shdiv_core.sv
module shdiv_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] dvd_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [WIDTH-1:0] q_q, r_q, d_q;
  logic [WIDTH:0]   shifted, diff;

  // restoring step: trial-subtract divisor from partial remainder
  always_comb begin
    shifted = {r_q, q_q[WIDTH-1]};
    diff    = shifted - {1'b0, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
      r_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      q_q <= dvd_i;
      r_q <= '0;
      d_q <= dvs_i;
    end else if (step_i) begin
      if (!diff[WIDTH]) begin
        r_q <= diff[WIDTH-1:0];
        q_q <= {q_q[WIDTH-2:0], 1'b1};
      end else begin
        r_q <= shifted[WIDTH-1:0];
        q_q <= {q_q[WIDTH-2:0], 1'b0};
      end
    end
  end

  assign quo_o = q_q;
  assign rem_o = r_q;

  // R1: partial remainder never reaches a nonzero divisor
  a_r1_rem_below_dvs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_q != '0) |-> (r_q < d_q));
endmodule

// File: rtl/shdiv_fix.sv
module shdiv_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo_abs_i,
  input  logic [WIDTH-1:0] rem_abs_i,
  input  logic             is_signed_i,
  input  logic             neg_quo_i,
  input  logic             neg_rem_i,
  input  logic             zero_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    if (zero_i) begin
      if (is_signed_i) quo_o = neg_rem_i ? MAX_NEG : MAX_POS;
      else             quo_o = '1;
    end else begin
      quo_o = neg_quo_i ? (~quo_abs_i + 1'b1) : quo_abs_i;
    end
    rem_o = neg_rem_i ? (~rem_abs_i + 1'b1) : rem_abs_i;
  end
endmodule

// File: rtl/shift_divider.sv
module shift_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_zero_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  import shdiv_pkg::*;

  localparam int SHW     = $clog2(WIDTH);
  localparam int CFG_W   = 3 * SHW + 3;
  localparam int LATENCY = WIDTH + 3;
  localparam int LW      = $clog2(LATENCY + 1) + 1;

  typedef struct packed {
    logic           res_right;
    logic [SHW-1:0] res_sh;
    logic [SHW-1:0] dvs_rsh;
    logic [SHW-1:0] dvd_lsh;
    logic           manual;
    logic           is_signed;
  } cfg_t;

  state_e state_q;
  logic [SHW-1:0]   cnt_q;
  logic [WIDTH-1:0] dvd_q, dvs_q, dvd_d, dvs_d;
  cfg_t             cfg_q, cfg_d, snap_cfg_q;
  logic [WIDTH-1:0] snap_dvd_q, snap_dvs_q;
  logic             go, dvs_wr;

  logic [WIDTH-1:0] abs_dvd, abs_dvs, core_quo, core_rem, fix_quo, fix_rem;
  logic             neg_quo, neg_rem, zero_dvs;
  logic             neg_quo_q, neg_rem_q, zero_q;
  logic [WIDTH-1:0] fix_quo_q, fix_rem_q, post_quo;
  logic [WIDTH-1:0] quot_q, rem_q;
  logic             zero_flag_q, done_q;

  // register file next values
  always_comb begin
    dvd_d  = dvd_q;
    dvs_d  = dvs_q;
    cfg_d  = cfg_q;
    dvs_wr = 1'b0;
    if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_DVD: dvd_d = wr_data_i;
        SEL_DVS: begin dvs_d = wr_data_i; dvs_wr = 1'b1; end
        SEL_CFG: cfg_d = cfg_t'(wr_data_i[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  assign go = (state_q == ST_IDLE) && (start_i || (dvs_wr && !cfg_q.manual));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q      <= '0;
      dvs_q      <= '0;
      cfg_q      <= '0;
      snap_dvd_q <= '0;
      snap_dvs_q <= '0;
      snap_cfg_q <= '0;
    end else begin
      dvd_q <= dvd_d;
      dvs_q <= dvs_d;
      cfg_q <= cfg_d;
      if (go) begin
        snap_dvd_q <= dvd_d;
        snap_dvs_q <= dvs_d;
        snap_cfg_q <= cfg_d;
      end
    end
  end

  shdiv_prep #(.WIDTH(WIDTH), .SHW(SHW)) u_prep (
    .dvd_i       (snap_dvd_q),
    .dvs_i       (snap_dvs_q),
    .is_signed_i (snap_cfg_q.is_signed),
    .dvd_lsh_i   (snap_cfg_q.dvd_lsh),
    .dvs_rsh_i   (snap_cfg_q.dvs_rsh),
    .abs_dvd_o   (abs_dvd),
    .abs_dvs_o   (abs_dvs),
    .neg_quo_o   (neg_quo),
    .neg_rem_o   (neg_rem),
    .zero_o      (zero_dvs)
  );

  shdiv_core #(.WIDTH(WIDTH)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_PREP),
    .step_i (state_q == ST_ITER),
    .dvd_i  (abs_dvd),
    .dvs_i  (abs_dvs),
    .quo_o  (core_quo),
    .rem_o  (core_rem)
  );

  shdiv_fix #(.WIDTH(WIDTH)) u_fix (
    .quo_abs_i   (core_quo),
    .rem_abs_i   (core_rem),
    .is_signed_i (snap_cfg_q.is_signed),
    .neg_quo_i   (neg_quo_q),
    .neg_rem_i   (neg_rem_q),
    .zero_i      (zero_q),
    .quo_o       (fix_quo),
    .rem_o       (fix_rem)
  );

  // quotient post-shift, bypassed on zero divisor
  always_comb begin
    if (zero_q)                    post_quo = fix_quo_q;
    else if (!snap_cfg_q.res_right) post_quo = fix_quo_q << snap_cfg_q.res_sh;
    else if (snap_cfg_q.is_signed) post_quo = WIDTH'($signed(fix_quo_q) >>> snap_cfg_q.res_sh);
    else                           post_quo = fix_quo_q >> snap_cfg_q.res_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      neg_quo_q   <= 1'b0;
      neg_rem_q   <= 1'b0;
      zero_q      <= 1'b0;
      fix_quo_q   <= '0;
      fix_rem_q   <= '0;
      quot_q      <= '0;
      rem_q       <= '0;
      zero_flag_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go) state_q <= ST_PREP;
        ST_PREP: begin
          neg_quo_q <= neg_quo;
          neg_rem_q <= neg_rem;
          zero_q    <= zero_dvs;
          cnt_q     <= '0;
          state_q   <= ST_ITER;
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SHW'(WIDTH - 1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          fix_quo_q <= fix_quo;
          fix_rem_q <= fix_rem;
          state_q   <= ST_POST;
        end
        ST_POST: begin
          quot_q      <= post_quo;
          rem_q       <= fix_rem_q;
          zero_flag_q <= zero_q;
          done_q      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign div_zero_o = zero_flag_q;
  assign quot_o     = quot_q;
  assign rem_o      = rem_q;

  // latency window counter for R6
  logic [LW-1:0] lat_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_cnt_q <= '0;
    else if (busy_o) lat_cnt_q <= lat_cnt_q + 1'b1;
    else             lat_cnt_q <= '0;
  end

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt_q == LW'(LATENCY)));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_zero_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o && !snap_cfg_q.is_signed) |-> (quot_o == '1));

  a_r10_no_disturb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_POST) |=>
      (busy_o && $stable(snap_dvd_q) && $stable(snap_dvs_q) && $stable(snap_cfg_q)));
endmodule

// File: tb/shift_divider_tb.sv
`timescale 1ns/1ps
module shift_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic        busy, done, dz;
  logic [31:0] quot, rem;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  shift_divider u_dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_sel_i (wr_sel),
    .wr_data_i (wr_data), .start_i (start), .busy_o (busy), .done_o (done),
    .div_zero_o (dz), .quot_o (quot), .rem_o (rem)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit sgn, input bit man, input int l,
                                         input int r, input int s, input bit right);
    logic [31:0] c;
    c = '0;
    c[0] = sgn; c[1] = man; c[6:2] = l[4:0]; c[11:7] = r[4:0];
    c[16:12] = s[4:0]; c[17] = right;
    return c;
  endfunction

  task automatic model(input logic [31:0] dvd, input logic [31:0] dvs, input logic [31:0] cfg,
                       output logic [31:0] q, output logic [31:0] r, output logic z);
    logic [31:0] a, b;
    longint sa, sb;
    a = dvd << cfg[6:2];
    b = cfg[0] ? 32'($signed(dvs) >>> cfg[11:7]) : (dvs >> cfg[11:7]);
    if (b == 0) begin
      z = 1'b1;
      r = a;
      q = cfg[0] ? (a[31] ? 32'h8000_0000 : 32'h7fff_ffff) : 32'hffff_ffff;
    end else begin
      z = 1'b0;
      if (cfg[0]) begin
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = 32'(sa / sb);
        r = 32'(sa % sb);
      end else begin
        q = a / b;
        r = a % b;
      end
      if (cfg[17]) q = cfg[0] ? 32'($signed(q) >>> cfg[16:12]) : (q >> cfg[16:12]);
      else         q = q << cfg[16:12];
    end
  endtask

  // one-cycle drive starting at a falling edge
  task automatic drive(input bit en, input logic [1:0] sel, input logic [31:0] d, input bit st);
    wr_en = en; wr_sel = sel; wr_data = d; start = st;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
  endtask

  task automatic wait_done(inout int n, input string req);
    bit busy_ok;
    busy_ok = 1'b1;
    while (!done && n < 100) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    check({req, "/R6 busy held"}, 32'(busy_ok), 32'd1);
  endtask

  task automatic finish_op(input int n0, input logic [31:0] dvd, input logic [31:0] dvs,
                           input logic [31:0] cfg, input string req);
    logic [31:0] eq, er;
    logic ez;
    int n;
    n = n0;
    model(dvd, dvs, cfg, eq, er, ez);
    wait_done(n, req);
    check("R6 latency", 32'(n), 32'd35);
    check("R7 not busy at done", 32'(busy), 32'd0);
    check({req, " quot"}, quot, eq);
    check({req, " rem"}, rem, er);
    check({req, "/R9 zero flag"}, 32'(dz), 32'(ez));
    @(negedge clk);
    check("R7 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic run_op(input logic [31:0] dvd, input logic [31:0] dvs,
                        input logic [31:0] cfg, input string req);
    drive(1'b1, 2'd2, cfg, 1'b0);
    drive(1'b1, 2'd0, dvd, 1'b0);
    if (cfg[1]) begin
      drive(1'b1, 2'd1, dvs, 1'b0);
      check("R8 manual no auto start", 32'(busy), 32'd0);
      drive(1'b0, 2'd0, '0, 1'b1);
    end else begin
      drive(1'b1, 2'd1, dvs, 1'b0);
    end
    finish_op(0, dvd, dvs, cfg, req);
  endtask

  initial begin
    #(5.0 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int dummy;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 done", 32'(done), 32'd0);
    check("R11 quot", quot, 32'd0);
    check("R11 rem", rem, 32'd0);
    check("R11 zero", 32'(dz), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'd100, 32'd7, mk_cfg(0,0,0,0,0,0), "R1");
    run_op(32'hffff_ffff, 32'h10, mk_cfg(0,0,0,0,0,0), "R1");
    run_op(32'd5, 32'd9, mk_cfg(0,0,0,0,0,0), "R1");
    run_op(-32'sd100, 32'd7, mk_cfg(1,0,0,0,0,0), "R2");
    run_op(32'd100, -32'sd7, mk_cfg(1,0,0,0,0,0), "R2");
    run_op(-32'sd100, -32'sd7, mk_cfg(1,0,0,0,0,0), "R2");
    run_op(32'h8000_0000, 32'hffff_ffff, mk_cfg(1,0,0,0,0,0), "R2");
    run_op(32'h123, 32'h10, mk_cfg(0,0,4,0,0,0), "R3");
    run_op(32'h1234_5678, 32'h0012_3400, mk_cfg(0,0,0,8,0,0), "R4");
    run_op(32'd1000, 32'hffff_0000, mk_cfg(1,0,0,8,0,0), "R4");
    run_op(32'd1000, 32'hffff_0000, mk_cfg(0,0,0,8,0,0), "R4");
    run_op(32'd1000, 32'd7, mk_cfg(0,0,0,0,3,0), "R5");
    run_op(-32'sd1000, 32'd7, mk_cfg(1,0,0,0,2,1), "R5");
    run_op(32'hf000_0000, 32'd1, mk_cfg(0,0,0,0,4,1), "R5");
    run_op(32'd77, 32'd0, mk_cfg(0,0,0,0,0,0), "R9");
    run_op(32'd77, 32'd0, mk_cfg(1,0,0,0,3,1), "R9");
    run_op(-32'sd77, 32'd0, mk_cfg(1,0,0,0,0,0), "R9");
    run_op(32'd50, 32'h0000_00ff, mk_cfg(0,0,0,8,2,0), "R9");
    run_op(32'd91, 32'd4, mk_cfg(0,1,0,0,0,0), "R8");

    // R10: collisions while busy are ignored, write still lands
    begin
      int n;
      drive(1'b1, 2'd2, mk_cfg(0,0,0,0,0,0), 1'b0);
      drive(1'b1, 2'd0, 32'd1000, 1'b0);
      drive(1'b1, 2'd1, 32'd7, 1'b0);
      n = 0;
      repeat (5) begin @(negedge clk); n++; end
      drive(1'b1, 2'd1, 32'd3, 1'b1);
      n++;
      finish_op(n, 32'd1000, 32'd7, mk_cfg(0,0,0,0,0,0), "R10");
      check("R10 idle after", 32'(busy), 32'd0);
      drive(1'b0, 2'd0, '0, 1'b1);
      finish_op(0, 32'd1000, 32'd3, mk_cfg(0,0,0,0,0,0), "R10");
    end

    // R1: sel code 3 ignored
    drive(1'b1, 2'd3, 32'd5, 1'b0);
    drive(1'b0, 2'd0, '0, 1'b1);
    finish_op(0, 32'd1000, 32'd3, mk_cfg(0,0,0,0,0,0), "R1 sel3");

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b, c;
      a = $urandom;
      b = ($urandom_range(0, 7) == 0) ? 32'd0 : ($urandom >> $urandom_range(0, 28));
      c = mk_cfg($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3),
                 $urandom_range(0,4), $urandom_range(0,5), $urandom_range(0,1));
      run_op(a, b, c, "R1/R2 random");
    end

    dummy = 0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule